// File: doc/BRIEF.md
# Load/Store Address and Sequencing Unit

This unit carries out the memory-movement instructions of a 16-bit instruction set. A controller hands it one instruction word together with the address of the following instruction. The unit forms the effective address, either relative to that program counter or relative to a base register. It then drives a single-port synchronous memory, whose read data returns one cycle after a read request. It writes loaded words or computed addresses back to the register file and raises `done` in the last cycle of the instruction.

The number of cycles depends on the instruction. Load-effective-address touches no memory and needs one cycle. Direct loads and stores need two cycles. The indirect forms first fetch a pointer and then make a second, dependent access through it, so they need three cycles. A new instruction can be taken in the cycle that `done` is high, so instructions can run back to back. Loads and address loads update a three-bit sign flag register, and stores leave it alone.

Top module: `ldst_seq_unit`

## Requirements
- R1: After reset, `done`, `err`, `mem_re`, `mem_we` and `rf_we` are low and `flags_nzp` is 3'b010 (bit 2 negative, bit 1 zero, bit 0 positive).
- R2: Opcodes 4'b0010 (load) and 4'b0011 (store) in bits 15:12 address memory at `pc_next` plus the sign-extended bits 8:0. A load reads in the first cycle and writes the returned word to the register named by bits 11:9 in the second cycle, with `done` high.
- R3: Opcodes 4'b0110 (load) and 4'b0111 (store) address memory at the value of the register named by bits 8:6 plus the sign-extended bits 5:0, with the same two-cycle timing as R2.
- R4: Opcode 4'b1110 writes `pc_next` plus the sign-extended bits 8:0 into the register named by bits 11:9 in its first and only cycle, with `done` high. It makes no memory request.
- R5: Opcodes 4'b1010 (load) and 4'b1011 (store) read a pointer at the PC-relative address in cycle 1. In cycle 2 they load or store at that pointer. `done` is high in cycle 3, and for the load the fetched word is written to the register file in that cycle.
- R6: Stores drive `mem_we` with `mem_wdata` equal to the register named by bits 11:9, and never write the register file. `done` is high in cycle 2 for the direct and based forms and in cycle 3 for the indirect form. `mem_re` and `mem_we` are never high together.
- R7: After each register-file write, `flags_nzp` holds exactly one bit: negative if bit 15 of the written value is set, zero if the value is zero, and positive otherwise. Without a write, the flags keep their value.
- R8: `start` is taken only while the unit is idle or `done` is high. Otherwise it is ignored and the running instruction finishes unchanged.
- R9: A taken `start` with any other opcode causes no memory or register activity. It pulses `err` for one cycle, in the cycle after the request, and the unit stays idle.
- R10: Offsets are two's complement and address arithmetic wraps modulo 2^16, including the extreme offsets (-256 and 255 for nine bits, -32 and 31 for six bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to take `instr` |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | Address of the following instruction |
| done | output | 1 | Last cycle of the running instruction |
| err | output | 1 | One-cycle pulse for a rejected opcode |
| flags_nzp | output | 3 | Negative, zero and positive flags |
| rf_base_sel | output | 3 | Register-file read select for the base register |
| rf_base_val | input | 16 | Value of the register selected by `rf_base_sel` |
| rf_src_sel | output | 3 | Register-file read select for the store source |
| rf_src_val | input | 16 | Value of the register selected by `rf_src_sel` |
| rf_we | output | 1 | Register-file write enable |
| rf_wsel | output | 3 | Register-file write select |
| rf_wdata | output | 16 | Register-file write data |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_re` |

## Verification
The bench goes after the pointer hop of the indirect forms. A design that used the first address again, or sampled the pointer a cycle too early, would load from or store to the wrong word. It offers a new instruction while one is running and again in the `done` cycle. A unit that took the first offer would corrupt the running instruction, and one that refused the second would add an idle cycle. It also drives the extreme offsets and zero and negative results, which expose a missing sign extension or a flag that was set wrongly or that changed on a store. Finally it sends illegal opcodes and checks that `err` pulses with no write leaking out.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
   // instruction layout (fixed by the instruction set)
   localparam int INSTR_W = 16;
   localparam int OPC_W   = 4;
   localparam int OPC_LSB = 12;
   localparam int RSEL_W  = 3;
   localparam int RD_LSB  = 9;
   localparam int RB_LSB  = 6;
   localparam int PCOFF_W = 9;
   localparam int BOFF_W  = 6;
   localparam int FLAG_W  = 3;

   localparam logic [OPC_W-1:0] OPC_LD  = 4'b0010;
   localparam logic [OPC_W-1:0] OPC_ST  = 4'b0011;
   localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
   localparam logic [OPC_W-1:0] OPC_STR = 4'b0111;
   localparam logic [OPC_W-1:0] OPC_LDI = 4'b1010;
   localparam logic [OPC_W-1:0] OPC_STI = 4'b1011;
   localparam logic [OPC_W-1:0] OPC_LEA = 4'b1110;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PTR,
      ST_FIN
   } seq_state_t;

   typedef struct packed {
      logic legal;
      logic lea;
      logic store;
      logic indirect;
      logic based;
   } op_kind_t;

   function automatic logic op_is_legal(input logic [OPC_W-1:0] opc);
      return (opc == OPC_LD)  || (opc == OPC_ST)  || (opc == OPC_LDR) ||
             (opc == OPC_STR) || (opc == OPC_LDI) || (opc == OPC_STI) ||
             (opc == OPC_LEA);
   endfunction
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
   import ldst_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output op_kind_t         kind
);
   always_comb begin
      kind = '0;
      case (opcode)
         OPC_LD:  kind.legal = 1'b1;
         OPC_ST:  begin kind.legal = 1'b1; kind.store = 1'b1; end
         OPC_LDR: begin kind.legal = 1'b1; kind.based = 1'b1; end
         OPC_STR: begin kind.legal = 1'b1; kind.based = 1'b1; kind.store = 1'b1; end
         OPC_LDI: begin kind.legal = 1'b1; kind.indirect = 1'b1; end
         OPC_STI: begin kind.legal = 1'b1; kind.indirect = 1'b1; kind.store = 1'b1; end
         OPC_LEA: begin kind.legal = 1'b1; kind.lea = 1'b1; end
         default: kind = '0;
      endcase
   end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen #(
   parameter int WORD_W       = 16,
   parameter int PC_OFF_W     = 9,
   parameter int BASE_OFF_W   = 6,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [WORD_W-1:0]     pc_val,
   input  logic [WORD_W-1:0]     base_val,
   input  logic [PC_OFF_W-1:0]   pc_off,
   input  logic [BASE_OFF_W-1:0] base_off,
   input  logic                  use_base,
   output logic [WORD_W-1:0]     ea
);
   localparam int PC_EXT_W   = WORD_W - PC_OFF_W;
   localparam int BASE_EXT_W = WORD_W - BASE_OFF_W;

   if (PC_OFF_W >= WORD_W || BASE_OFF_W >= WORD_W) begin : g_bad_width
      $error("ldst_agen: offsets must be narrower than WORD_W");
   end

   logic [WORD_W-1:0] pc_off_x;
   logic [WORD_W-1:0] base_off_x;

   assign pc_off_x   = {{PC_EXT_W{pc_off[PC_OFF_W-1]}}, pc_off};
   assign base_off_x = {{BASE_EXT_W{base_off[BASE_OFF_W-1]}}, base_off};

   if (SHARED_ADDER) begin : g_shared
      // one adder, operands muxed in front of it
      logic [WORD_W-1:0] op_a;
      logic [WORD_W-1:0] op_b;
      assign op_a = use_base ? base_val   : pc_val;
      assign op_b = use_base ? base_off_x : pc_off_x;
      assign ea   = op_a + op_b;
   end else begin : g_dual
      // two adders in parallel, result muxed after them
      logic [WORD_W-1:0] sum_pc;
      logic [WORD_W-1:0] sum_base;
      assign sum_pc   = pc_val + pc_off_x;
      assign sum_base = base_val + base_off_x;
      assign ea       = use_base ? sum_base : sum_pc;
   end
endmodule

// File: rtl/ldst_flags.sv
module ldst_flags
   import ldst_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [WORD_W-1:0] value,
   output logic [FLAG_W-1:0] nzp
);
   logic [FLAG_W-1:0] nzp_d;

   always_comb begin
      if (value[WORD_W-1])   nzp_d = 3'b100;
      else if (value == '0)  nzp_d = 3'b010;
      else                   nzp_d = 3'b001;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   nzp <= 3'b010;
      else if (upd) nzp <= nzp_d;
   end

   // R7: exactly one flag at all times
   a_r7_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(nzp) == 1);

   // R7: flags only move after a register write
   a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(nzp));
endmodule

// File: rtl/ldst_seq_unit.sv
module ldst_seq_unit
   import ldst_pkg::*;
#(
   parameter int WORD_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [INSTR_W-1:0] instr,
   input  logic [WORD_W-1:0]  pc_next,
   output logic               done,
   output logic               err,
   output logic [FLAG_W-1:0]  flags_nzp,
   output logic [RSEL_W-1:0]  rf_base_sel,
   input  logic [WORD_W-1:0]  rf_base_val,
   output logic [RSEL_W-1:0]  rf_src_sel,
   input  logic [WORD_W-1:0]  rf_src_val,
   output logic               rf_we,
   output logic [RSEL_W-1:0]  rf_wsel,
   output logic [WORD_W-1:0]  rf_wdata,
   output logic               mem_re,
   output logic               mem_we,
   output logic [WORD_W-1:0]  mem_addr,
   output logic [WORD_W-1:0]  mem_wdata,
   input  logic [WORD_W-1:0]  mem_rdata
);
   if (WORD_W < INSTR_W) begin : g_bad_word
      $error("ldst_seq_unit: WORD_W must be at least the instruction width");
   end

   seq_state_t          state_q, state_d;
   logic [INSTR_W-1:0]  ir_q;
   logic [WORD_W-1:0]   pc_q;
   logic                err_q;
   op_kind_t            kind_q;
   logic [WORD_W-1:0]   ea;
   logic                ready;
   logic                take;
   logic                accept;

   ldst_decode u_decode (
      .opcode (ir_q[OPC_LSB +: OPC_W]),
      .kind   (kind_q)
   );

   ldst_agen #(
      .WORD_W       (WORD_W),
      .PC_OFF_W     (PCOFF_W),
      .BASE_OFF_W   (BOFF_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_agen (
      .pc_val   (pc_q),
      .base_val (rf_base_val),
      .pc_off   (ir_q[PCOFF_W-1:0]),
      .base_off (ir_q[BOFF_W-1:0]),
      .use_base (kind_q.based),
      .ea       (ea)
   );

   ldst_flags #(.WORD_W(WORD_W)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (rf_we),
      .value (rf_wdata),
      .nzp   (flags_nzp)
   );

   // completion: LEA ends in its address cycle, all others in FIN
   assign done   = (state_q == ST_FIN) || ((state_q == ST_ADDR) && kind_q.lea);
   assign ready  = (state_q == ST_IDLE) || done;
   assign take   = start && ready;
   assign accept = take && op_is_legal(instr[OPC_LSB +: OPC_W]);

   assign rf_base_sel = ir_q[RB_LSB +: RSEL_W];
   assign rf_src_sel  = ir_q[RD_LSB +: RSEL_W];
   assign rf_wsel     = ir_q[RD_LSB +: RSEL_W];
   assign err         = err_q;

   always_comb begin
      state_d   = state_q;
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = ea;
      mem_wdata = rf_src_val;
      rf_we     = 1'b0;
      rf_wdata  = mem_rdata;
      case (state_q)
         ST_IDLE: begin
            if (accept) state_d = ST_ADDR;
         end
         ST_ADDR: begin
            if (kind_q.lea) begin
               rf_we    = 1'b1;
               rf_wdata = ea;
               state_d  = accept ? ST_ADDR : ST_IDLE;
            end else if (kind_q.store && !kind_q.indirect) begin
               mem_we  = 1'b1;
               state_d = ST_FIN;
            end else begin
               mem_re  = 1'b1;
               state_d = kind_q.indirect ? ST_PTR : ST_FIN;
            end
         end
         ST_PTR: begin
            // pointer returned by the first read addresses the data access
            mem_addr = mem_rdata;
            if (kind_q.store) mem_we = 1'b1;
            else              mem_re = 1'b1;
            state_d = ST_FIN;
         end
         ST_FIN: begin
            rf_we   = !kind_q.store;
            state_d = accept ? ST_ADDR : ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ir_q    <= '0;
         pc_q    <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= take && !op_is_legal(instr[OPC_LSB +: OPC_W]);
         if (accept) begin
            ir_q <= instr;
            pc_q <= pc_next;
         end
      end
   end

   // R6: one memory direction per cycle
   a_r6_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R9: a rejected opcode leaves no trace besides err
   a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!mem_re && !mem_we && !rf_we && !done));

   // R9: only legal opcodes ever run
   a_r9_running_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> kind_q.legal);

   // R5: indirect forms go through the pointer state
   a_r5_ptr_hop: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR && kind_q.indirect) |=> (state_q == ST_PTR));

   // R4: LEA never reaches the later states
   a_r4_lea_single: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR && kind_q.lea) |=> (state_q == ST_IDLE || state_q == ST_ADDR));

   // R8: a running instruction is not replaced before done
   a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !done) |=> $stable(ir_q));
endmodule

// File: tb/ldst_seq_unit_tb.sv
module ldst_seq_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   typedef struct {
      bit          re;
      bit          we;
      logic [15:0] addr;
      logic [15:0] wdata;
      bit          rfwe;
      logic [2:0]  sel;
      logic [15:0] rfdata;
      bit          dn;
      int          req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] pc_next = '0;
   logic        done, err;
   logic [2:0]  flags_nzp;
   logic [2:0]  rf_base_sel, rf_src_sel, rf_wsel;
   logic [15:0] rf_base_val, rf_src_val, rf_wdata;
   logic        rf_we, mem_re, mem_we;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;

   logic [15:0] regs [8];
   logic [15:0] mem  [256];
   logic [15:0] ref_regs [8];
   logic [15:0] ref_mem  [256];

   exp_t q[$];
   int   checks = 0;
   int   bad = 0;
   int   idle_req = 1;
   bit   exp_err = 1'b0;
   logic [2:0] exp_flags = 3'b010;
   bit   finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldst_seq_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_next(pc_next),
      .done(done), .err(err), .flags_nzp(flags_nzp),
      .rf_base_sel(rf_base_sel), .rf_base_val(rf_base_val),
      .rf_src_sel(rf_src_sel), .rf_src_val(rf_src_val),
      .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // environment: register file with combinational reads, synchronous memory
   assign rf_base_val = regs[rf_base_sel];
   assign rf_src_val  = regs[rf_src_sel];

   always @(posedge clk) begin
      if (rf_we) regs[rf_wsel] <= rf_wdata;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
   end

   function automatic logic [15:0] init_word(int i);
      logic [15:0] w;
      w = 16'(i * 37 + 5);
      if (i % 5 == 0) w = w | 16'h8000;
      return w;
   endfunction

   function automatic logic [2:0] nzp_of(logic [15:0] v);
      if (v[15])           return 3'b100;
      else if (v == 16'h0) return 3'b010;
      else                 return 3'b001;
   endfunction

   function automatic logic [15:0] mk_pc(logic [3:0] op, int r, int off);
      logic [15:0] w;
      w = {op, 3'(r), 9'(off)};
      return w;
   endfunction

   function automatic logic [15:0] mk_base(logic [3:0] op, int r, int b, int off);
      logic [15:0] w;
      w = {op, 3'(r), 3'(b), 6'(off)};
      return w;
   endfunction

   task automatic chk(bit ok, int req, string what, logic [15:0] act, logic [15:0] expv);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic push(bit re, bit we, logic [15:0] a, logic [15:0] wd, bit rfwe,
                       logic [2:0] s, logic [15:0] rd, bit dn, int req);
      exp_t e;
      e.re = re; e.we = we; e.addr = a; e.wdata = wd; e.rfwe = rfwe;
      e.sel = s; e.rfdata = rd; e.dn = dn; e.req = req;
      q.push_back(e);
   endtask

   // behavioural model: applies the whole instruction and queues its cycles
   task automatic model_accept(logic [15:0] iw, logic [15:0] pc);
      logic [3:0]  op;
      logic [2:0]  dr, br;
      logic [15:0] pcrel, based, ptr, v;
      op    = iw[15:12];
      dr    = iw[11:9];
      br    = iw[8:6];
      pcrel = pc + {{7{iw[8]}}, iw[8:0]};
      based = ref_regs[br] + {{10{iw[5]}}, iw[5:0]};
      case (op)
         4'b1110: begin // R4 LEA
            push(0, 0, 0, 0, 1, dr, pcrel, 1, 4);
            ref_regs[dr] = pcrel;
         end
         4'b0010: begin // R2 load
            v = ref_mem[pcrel[7:0]];
            push(1, 0, pcrel, 0, 0, 0, 0, 0, 2);
            push(0, 0, 0, 0, 1, dr, v, 1, 2);
            ref_regs[dr] = v;
         end
         4'b0110: begin // R3 based load
            v = ref_mem[based[7:0]];
            push(1, 0, based, 0, 0, 0, 0, 0, 3);
            push(0, 0, 0, 0, 1, dr, v, 1, 3);
            ref_regs[dr] = v;
         end
         4'b0011: begin // R6 store (R2 addressing)
            push(0, 1, pcrel, ref_regs[dr], 0, 0, 0, 0, 6);
            push(0, 0, 0, 0, 0, 0, 0, 1, 6);
            ref_mem[pcrel[7:0]] = ref_regs[dr];
         end
         4'b0111: begin // R6 store (R3 addressing)
            push(0, 1, based, ref_regs[dr], 0, 0, 0, 0, 6);
            push(0, 0, 0, 0, 0, 0, 0, 1, 6);
            ref_mem[based[7:0]] = ref_regs[dr];
         end
         4'b1010: begin // R5 indirect load
            ptr = ref_mem[pcrel[7:0]];
            v   = ref_mem[ptr[7:0]];
            push(1, 0, pcrel, 0, 0, 0, 0, 0, 5);
            push(1, 0, ptr, 0, 0, 0, 0, 0, 5);
            push(0, 0, 0, 0, 1, dr, v, 1, 5);
            ref_regs[dr] = v;
         end
         4'b1011: begin // R5 indirect store
            ptr = ref_mem[pcrel[7:0]];
            push(1, 0, pcrel, 0, 0, 0, 0, 0, 5);
            push(0, 1, ptr, ref_regs[dr], 0, 0, 0, 0, 5);
            push(0, 0, 0, 0, 0, 0, 0, 1, 5);
            ref_mem[ptr[7:0]] = ref_regs[dr];
         end
         default: ;
      endcase
   endtask

   function automatic bit legal_op(logic [3:0] op);
      return op == 4'b0010 || op == 4'b0011 || op == 4'b0110 || op == 4'b0111 ||
             op == 4'b1010 || op == 4'b1011 || op == 4'b1110;
   endfunction

   // one clock: compare at the falling edge, then drive and advance
   task automatic step(bit st, logic [15:0] iw, logic [15:0] pc);
      exp_t e;
      bit   can_take;
      bit   nxt_err;
      if (q.size() > 0) e = q[0];
      else begin
         e.re = 0; e.we = 0; e.addr = 0; e.wdata = 0; e.rfwe = 0;
         e.sel = 0; e.rfdata = 0; e.dn = 0; e.req = idle_req;
      end
      chk(mem_re === e.re, e.req, "mem_re", 16'(mem_re), 16'(e.re));
      chk(mem_we === e.we, e.req, "mem_we", 16'(mem_we), 16'(e.we));
      if (e.re || e.we)
         chk(mem_addr === e.addr, e.req, "mem_addr", mem_addr, e.addr);
      if (e.we)
         chk(mem_wdata === e.wdata, e.req, "mem_wdata", mem_wdata, e.wdata);
      chk(rf_we === e.rfwe, e.req, "rf_we", 16'(rf_we), 16'(e.rfwe));
      if (e.rfwe) begin
         chk(rf_wsel === e.sel, e.req, "rf_wsel", 16'(rf_wsel), 16'(e.sel));
         chk(rf_wdata === e.rfdata, e.req, "rf_wdata", rf_wdata, e.rfdata);
      end
      chk(done === e.dn, e.req, "done", 16'(done), 16'(e.dn));
      chk(err === exp_err, 9, "err (R9)", 16'(err), 16'(exp_err));
      chk(flags_nzp === exp_flags, 7, "flags (R7)", 16'(flags_nzp), 16'(exp_flags));

      start   = st;
      instr   = iw;
      pc_next = pc;
      can_take = (q.size() == 0) || q[0].dn;
      if (q.size() > 0) begin
         if (q[0].rfwe) exp_flags = nzp_of(q[0].rfdata);
         void'(q.pop_front());
      end
      nxt_err = 1'b0;
      if (st && can_take) begin
         if (legal_op(iw[15:12])) model_accept(iw, pc);
         else nxt_err = 1'b1;
      end
      @(posedge clk);
      exp_err = nxt_err;
      @(negedge clk);
   endtask

   task automatic drain();
      while (q.size() > 0 || exp_err) step(0, 16'h0, 16'h0);
      step(0, 16'h0, 16'h0);
   endtask

   task automatic run(logic [15:0] iw, logic [15:0] pc);
      step(1, iw, pc);
      drain();
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         regs[i]     = 16'h0040 + 16'(i * 9);
         ref_regs[i] = 16'h0040 + 16'(i * 9);
      end
      for (int i = 0; i < 256; i++) begin
         mem[i]     = init_word(i);
         ref_mem[i] = init_word(i);
      end
      mem_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      idle_req = 1;
      step(0, 16'h0, 16'h0);
      step(0, 16'h0, 16'h0);

      idle_req = 8;
      // R4: LEA positive, zero and negative results (R7 flags)
      run(mk_pc(4'b1110, 1, 5), 16'h3010);
      run(mk_pc(4'b1110, 6, -3), 16'h0003);
      run(mk_pc(4'b1110, 7, -1), 16'h0000);
      // R10: extreme nine-bit offsets
      run(mk_pc(4'b1110, 2, 255), 16'h3000);
      run(mk_pc(4'b1110, 3, -256), 16'h0010);

      // R2: PC-relative load and store, then reload the stored word
      run(mk_pc(4'b0010, 4, 7), 16'h3020);
      run(mk_pc(4'b0011, 5, -9), 16'h3040);
      run(mk_pc(4'b0010, 0, -9), 16'h3040);
      run(mk_pc(4'b0010, 2, 3), 16'h0002);  // word 5: bit 15 set, flags N

      // R3: base-plus-offset with R10 extreme six-bit offsets
      run(mk_base(4'b0110, 3, 1, -32), 16'h0);
      run(mk_base(4'b0110, 4, 5, 31), 16'h0);
      run(mk_base(4'b0111, 6, 2, -5), 16'h0);
      run(mk_base(4'b0110, 0, 2, -5), 16'h0);

      // R5: indirect load and store
      run(mk_pc(4'b1010, 1, 20), 16'h3100);
      run(mk_pc(4'b1011, 3, -40), 16'h3100);
      run(mk_pc(4'b1010, 5, -40), 16'h3100);

      // R8: offer while busy is ignored, offer in the done cycle is taken
      step(1, mk_pc(4'b0010, 2, 11), 16'h3200);
      step(1, mk_pc(4'b1110, 4, 1), 16'h1000);
      step(1, mk_pc(4'b1110, 4, 1), 16'h1000);
      step(1, mk_pc(4'b1010, 6, 2), 16'h3300);
      step(1, mk_pc(4'b0011, 6, 0), 16'h3400);
      step(1, mk_pc(4'b0011, 6, 0), 16'h3400);
      drain();
      // R8: back-to-back LEA chain
      step(1, mk_pc(4'b1110, 1, 8), 16'h2000);
      step(1, mk_pc(4'b1110, 2, -8), 16'h2000);
      drain();

      // R9: illegal opcodes, idle and during a done cycle
      idle_req = 9;
      run(16'h1234, 16'h3000);
      run(16'hF000, 16'h3000);
      step(1, mk_pc(4'b0011, 1, 4), 16'h3500);
      step(0, 16'h0, 16'h0);
      step(1, 16'h5555, 16'h3500);
      drain();
      run(mk_pc(4'b0010, 3, 4), 16'h3500);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         bad++;
         $display("FAIL R8 watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule